// File: doc/BRIEF.md
# Gated Seven-Decade BCD Event Counter

This block counts events in decimal. A synchronous count enable, qualified by a gate input, advances a chain of BCD decade stages by one per clock. A carry ripples through every stage in the same clock. A separate storage register holds the digits that a display reads, together with an overflow flag. That register changes only when a latch strobe arrives. The running decades can therefore be cleared and can count a new sample while the stored result stays steady.

A typical use follows a measurement cycle. The user pulses clear, opens the gate for an interval, closes it, and then pulses latch. If the count passes the capacity of the decade chain, the chain wraps to zero and the running overflow flag is set. The flag stays set until a clear and is captured into storage with the digits. The number of decades is a parameter and defaults to seven.

Top module: `bcd_gated_counter`

## Requirements
- R1: While reset is high, and on the first cycle after reset is released, every output digit reads 0 and the overflow output reads 0.
- R2: On each clock edge where the gate and the count enable are both high and clear is low, the running count rises by exactly one.
- R3: On an edge where the gate or the count enable is low, and clear is low, the running count and the running overflow flag keep their values.
- R4: A decade at 9 that receives an increment goes to 0 and increments the next more significant decade on the same edge. For example, 19 becomes 20 and 999 becomes 1000.
- R5: Clear sets every running decade and the running overflow flag to zero on the next edge. Clear wins over a simultaneous count.
- R6: A latch strobe copies the running digits and the running overflow flag, as they stood before that same edge, into storage. The copy is visible on the outputs right after that edge. Output bits [4i+3:4i] carry decade i in BCD, and decade 0 is the least significant.
- R7: While latch is low, the stored digits and the stored overflow output do not change, whatever clear, gate or count do.
- R8: An increment of the all-nines count makes every decade 0 and sets the running overflow flag. The flag reaches the output at the next latch.
- R9: Once set, the running overflow flag stays set through further counting and through latches until a clear.
- R10: Every output digit always lies in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| cntEn | input | 1 | Conditioned count event, one increment per clock while high |
| gateOpen | input | 1 | Counting allowed while high |
| latchStb | input | 1 | Copy the running count into storage |
| clearStb | input | 1 | Zero the running decades and running overflow |
| digitsOut | output | 4*DIGITS (28) | Stored BCD digits, decade 0 in bits [3:0] |
| ovfOut | output | 1 | Stored overflow flag |

## Verification
Counting, gating and clearing act on the running decades at the edge where the inputs are sampled. They reach the ports only through a latch strobe, and the latched value appears directly after the edge that sampled that strobe. The bench drives each input on a falling edge and updates its model at the following rising edge. It compares both outputs on the next falling edge, so every comparison falls one full register stage after the stimulus. A second instance with three decades reaches the overflow boundary within the cycle budget. The same cycle-by-cycle reference model checks both instances.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
  localparam int DEF_DIGITS = 7;
  localparam int BCD_W      = 4;

  typedef struct packed {
    logic clr;
    logic inc;
    logic cap;
  } ctrStrobes_t;
endpackage

// File: rtl/bcd_ctr_ctrl.sv
module bcd_ctr_ctrl
  import bcd_ctr_pkg::*;
(
  input  logic        gateOpen,
  input  logic        cntEn,
  input  logic        latchStb,
  input  logic        clearStb,
  output ctrStrobes_t strobes
);
  always_comb begin
    strobes.clr = clearStb;
    // clear takes priority over counting
    strobes.inc = gateOpen && cntEn && !clearStb;
    strobes.cap = latchStb;
  end
endmodule

// File: rtl/bcd_ctr_decade.sv
module bcd_ctr_decade
  import bcd_ctr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             incIn,
  output logic [BCD_W-1:0] digit,
  output logic             carryOut
);
  localparam logic [BCD_W-1:0] TOP_VAL = BCD_W'(9);

  assign carryOut = incIn && (digit == TOP_VAL);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)             digit <= '0;
    else if (clr)        digit <= '0;
    else if (incIn) begin
      if (digit == TOP_VAL) digit <= '0;
      else                  digit <= digit + BCD_W'(1);
    end
  end
endmodule

// File: rtl/bcd_ctr_datapath.sv
module bcd_ctr_datapath
  import bcd_ctr_pkg::*;
#(
  parameter int DIGITS = DEF_DIGITS,
  localparam int TOT_W = DIGITS * BCD_W
)(
  input  logic             clk,
  input  logic             rst,
  input  ctrStrobes_t      strobes,
  output logic [TOT_W-1:0] runDigits,
  output logic             runOvf,
  output logic [TOT_W-1:0] storeDigits,
  output logic             storeOvf
);
  logic [DIGITS:0] carryChain;
  assign carryChain[0] = strobes.inc;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dec
    bcd_ctr_decade u_dec (
      .clk     (clk),
      .rst     (rst),
      .clr     (strobes.clr),
      .incIn   (carryChain[g]),
      .digit   (runDigits[g*BCD_W +: BCD_W]),
      .carryOut(carryChain[g+1])
    );
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                     runOvf <= 1'b0;
    else if (strobes.clr)        runOvf <= 1'b0;
    else if (carryChain[DIGITS]) runOvf <= 1'b1;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      storeDigits <= '0;
      storeOvf    <= 1'b0;
    end else if (strobes.cap) begin
      storeDigits <= runDigits;
      storeOvf    <= runOvf;
    end
  end
endmodule

// File: rtl/bcd_gated_counter.sv
module bcd_gated_counter
  import bcd_ctr_pkg::*;
#(
  parameter int DIGITS = DEF_DIGITS
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cntEn,
  input  logic                    gateOpen,
  input  logic                    latchStb,
  input  logic                    clearStb,
  output logic [DIGITS*BCD_W-1:0] digitsOut,
  output logic                    ovfOut
);
  ctrStrobes_t             strobes;
  logic [DIGITS*BCD_W-1:0] runDigits;
  logic                    runOvf;

  bcd_ctr_ctrl u_ctrl (
    .gateOpen(gateOpen),
    .cntEn   (cntEn),
    .latchStb(latchStb),
    .clearStb(clearStb),
    .strobes (strobes)
  );

  bcd_ctr_datapath #(.DIGITS(DIGITS)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .runDigits  (runDigits),
    .runOvf     (runOvf),
    .storeDigits(digitsOut),
    .storeOvf   (ovfOut)
  );
endmodule

// File: rtl/bcd_gated_counter_chk.sv
module bcd_gated_counter_chk
  import bcd_ctr_pkg::*;
#(
  parameter int DIGITS = DEF_DIGITS
)(
  input logic                    clk,
  input logic                    rst,
  input logic                    cntEn,
  input logic                    gateOpen,
  input logic                    latchStb,
  input logic                    clearStb,
  input logic [DIGITS*BCD_W-1:0] digitsOut,
  input logic                    ovfOut,
  input logic [DIGITS*BCD_W-1:0] runDigits,
  input logic                    runOvf
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (gateOpen && cntEn && !clearStb) |=>
      runDigits[BCD_W-1:0] == (($past(runDigits[BCD_W-1:0]) == 4'd9) ? 4'd0
                               : $past(runDigits[BCD_W-1:0]) + 4'd1));

  // R3
  gate_closed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clearStb && !(gateOpen && cntEn)) |=> ($stable(runDigits) && $stable(runOvf)));

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clearStb |=> (runDigits == '0 && !runOvf));

  // R6
  latch_copy_chk: assert property (@(posedge clk) disable iff (rst)
    latchStb |=> (digitsOut == $past(runDigits) && ovfOut == $past(runOvf)));

  // R7
  store_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !latchStb |=> ($stable(digitsOut) && $stable(ovfOut)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (runOvf && !clearStb) |=> runOvf);

  for (genvar g = 0; g < DIGITS; g++) begin : g_rng
    // R10
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      digitsOut[g*BCD_W +: BCD_W] <= 4'd9);
  end
endmodule

bind bcd_gated_counter bcd_gated_counter_chk #(.DIGITS(DIGITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cntEn    (cntEn),
  .gateOpen (gateOpen),
  .latchStb (latchStb),
  .clearStb (clearStb),
  .digitsOut(digitsOut),
  .ovfOut   (ovfOut),
  .runDigits(runDigits),
  .runOvf   (runOvf)
);

// File: tb/test_bcd_gated_counter.sv
`timescale 1ns/1ps
module test_bcd_gated_counter;
  localparam int BIG = 7;
  localparam int SML = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cntEn = 1'b0, gateOpen = 1'b0, latchStb = 1'b0, clearStb = 1'b0;
  logic [BIG*4-1:0] digA;
  logic [SML*4-1:0] digB;
  logic ovfA, ovfB;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int runA = 0, storeA = 0, runB = 0, storeB = 0;
  bit rOvfA = 0, sOvfA = 0, rOvfB = 0, sOvfB = 0;

  always #5 clk = ~clk;

  bcd_gated_counter #(.DIGITS(BIG)) i_bcd_gated_counter (
    .clk(clk), .rst(rst), .cntEn(cntEn), .gateOpen(gateOpen),
    .latchStb(latchStb), .clearStb(clearStb), .digitsOut(digA), .ovfOut(ovfA));

  bcd_gated_counter #(.DIGITS(SML)) i_bcd_gated_counter_small (
    .clk(clk), .rst(rst), .cntEn(cntEn), .gateOpen(gateOpen),
    .latchStb(latchStb), .clearStb(clearStb), .digitsOut(digB), .ovfOut(ovfB));

  function automatic logic [BIG*4-1:0] toBcd(int val, int n);
    logic [BIG*4-1:0] r = '0;
    int v = val;
    for (int i = 0; i < n; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int pow10(int n);
    int p = 1;
    for (int i = 0; i < n; i++) p = p * 10;
    return p;
  endfunction

  function automatic bit digitsLegal(logic [BIG*4-1:0] d);
    for (int i = 0; i < BIG; i++) if (d[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  task automatic modelEdge();
    storeA = latchStb ? runA : storeA;  sOvfA = latchStb ? rOvfA : sOvfA;
    storeB = latchStb ? runB : storeB;  sOvfB = latchStb ? rOvfB : sOvfB;
    if (clearStb) begin
      runA = 0; rOvfA = 0; runB = 0; rOvfB = 0;
    end else if (gateOpen && cntEn) begin
      runA++; if (runA == pow10(BIG)) begin runA = 0; rOvfA = 1; end
      runB++; if (runB == pow10(SML)) begin runB = 0; rOvfB = 1; end
    end
  endtask

  task automatic cyc(bit g, bit c, bit l, bit k);
    gateOpen = g; cntEn = c; latchStb = l; clearStb = k;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic checkOut(string req);
    logic [BIG*4-1:0] expA, expB;
    expA = toBcd(storeA, BIG);
    expB = toBcd(storeB, SML);
    checks++;
    if (digA !== expA || ovfA !== sOvfA) begin
      errors++;
      $display("FAIL %s wide: digits=%h ovf=%b expected digits=%h ovf=%b", req, digA, ovfA, expA, sOvfA);
    end
    checks++;
    if (digB !== expB[SML*4-1:0] || ovfB !== sOvfB) begin
      errors++;
      $display("FAIL %s narrow: digits=%h ovf=%b expected digits=%h ovf=%b", req, digB, ovfB, expB[SML*4-1:0], sOvfB);
    end
  endtask

  task automatic countN(int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk); @(negedge clk);
    checkOut("R1");
    rst = 1'b0;
    cyc(0, 0, 0, 0);
    checkOut("R1");

    // R2: five counts then latch
    countN(5);
    cyc(0, 0, 1, 0);
    checkOut("R2");

    // R3: gate low, then count enable low
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 0);
    checkOut("R3");
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 0);
    checkOut("R3");

    // R4: carry 19 -> 20 and 999 -> 1000
    countN(14);
    cyc(0, 0, 1, 0);
    checkOut("R4");
    countN(1);
    cyc(0, 0, 1, 0);
    checkOut("R4");
    countN(979);
    cyc(0, 0, 1, 0);
    checkOut("R4");
    // R8: wide reaches 1000, narrow wraps to 000 with overflow
    countN(1);
    cyc(0, 0, 1, 0);
    checkOut("R8");

    // R9: more counting and latches keep overflow
    countN(37);
    cyc(0, 0, 1, 0);
    checkOut("R9");
    cyc(0, 0, 1, 0);
    checkOut("R9");

    // R6: latch during counting captures the pre-edge value
    cyc(1, 1, 1, 0);
    checkOut("R6");

    // R7: clear and count without latch, storage holds
    cyc(1, 1, 0, 1);
    checkOut("R7");
    for (int i = 0; i < 20; i++) begin
      cyc(1, 1, 0, 0);
      checkOut("R7");
    end

    // R5: clear with count high wins, then latch shows zero
    cyc(1, 1, 0, 1);
    cyc(0, 0, 1, 0);
    checkOut("R5");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit g, c, l, k;
      g = ($urandom % 100) < 85;
      c = ($urandom % 100) < 75;
      l = ($urandom % 100) < 12;
      k = ($urandom % 1000) < 3;
      cyc(g, c, l, k);
      checkOut(l ? "R6" : "R7");
      checks++;
      if (!digitsLegal(digA)) begin
        errors++;
        $display("FAIL R10: digits=%h expected all decades <= 9", digA);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule